// File: doc/BRIEF.md
# Interrupt Pending and Request Controller

This block keeps an eight-line interrupt-pending vector for a processor core and decides whether the core has to take an interrupt exception. Each line can be set or cleared on its own, and one request clears the whole vector. An internal free-running counter is compared with a loadable compare value. When the two are equal, the pending line picked by a 3-bit select field is set. The counter is never allowed to trigger a match while it reads zero.

The decision to interrupt comes from three status inputs: a global enable, an exception-in-progress flag and an error-in-progress flag. It also needs at least one line that is both pending and unmasked. The result is held in a flop, so the request pin is driven straight from a register.

All pins are plain level-sensitive control and status signals sampled on the rising clock edge. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_pend_ctrl`

## Requirements
- R1: During and right after reset, `pend_o` is 0, `irq_o` is 0, `count_o` is 0 and the internal compare value is 0.
- R2: Bit n of `post_i` set in a cycle makes `pend_o[n]` 1 after the next rising edge, and leaves every other pending bit unchanged.
- R3: Bit n of `clr_i` set in a cycle makes `pend_o[n]` 0 after the next rising edge. It wins over a post or a timer set aimed at the same line in that cycle, and it leaves the other bits unchanged.
- R4: `clr_all_i` high in a cycle makes `pend_o` equal 0 after the next rising edge. It wins over any post or timer set in that cycle.
- R5: `irq_o` can be 1 only when the enable, exception and error inputs were 1, 0 and 0 at the edge that loaded it. If any of those conditions fails, `irq_o` is 0 after that edge.
- R6: After each edge, `irq_o` is 1 only if some line is set both in the new `pend_o` and in the `mask_i` sampled at that edge. A pending line whose mask bit is 0 never raises `irq_o` on its own.
- R7: `count_o` increases by exactly 1 on every edge out of reset and wraps modulo 2^CNT_W. A cycle with `cmp_we_i` high loads `cmp_wdata_i` into the compare value at that edge.
- R8: A timer match is a cycle in which the compare value equals `count_o` and `count_o` is nonzero. A match sets pending bit `tsel_i` at the next edge, where `tsel_i` is read as an unsigned binary line index 0..7.
- R9: When the compare value equals `count_o` and both are zero, no pending bit is set and `any_pend_o` stays low.
- R10: In every cycle, `any_pend_o` is 1 exactly when `pend_o` is nonzero or a timer match is present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| post_i | input | 8 | Per-line set requests, bit n = line n |
| clr_i | input | 8 | Per-line clear requests, bit n = line n |
| clr_all_i | input | 1 | Clear the whole pending vector |
| gie_i | input | 1 | Global interrupt enable |
| exl_i | input | 1 | Exception level active |
| erl_i | input | 1 | Error level active |
| mask_i | input | 8 | Per-line interrupt mask, 1 = enabled |
| cmp_we_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | CNT_W | Compare value write data |
| tsel_i | input | 3 | Pending line driven by the timer |
| count_o | output | CNT_W | Free-running count value |
| pend_o | output | 8 | Pending vector |
| any_pend_o | output | 1 | Pending vector or current timer match nonzero |
| irq_o | output | 1 | Registered take-interrupt request |

## Verification
The timer match and the clear-all request can land in the same cycle. So can a post and a clear aimed at one line. The bench watches `count_o` to find the exact cycle in which the counter will equal a compare value it just loaded, and raises clear-all in that cycle. It then expects `pend_o` to be zero one edge later, even though `any_pend_o` showed the match. The same-line post/clear collision is judged by expecting the line to read 0 while a post on a different line in that cycle still lands.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned SEL_W     = $clog2(NUM_LINES);

  typedef logic [NUM_LINES-1:0] line_vec_t;
  typedef logic [SEL_W-1:0]     line_sel_t;
endpackage

// File: rtl/irq_timer.sv
module irq_timer
  import irq_pend_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  line_sel_t        tsel_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_o,
  output line_vec_t        tset_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      cmp_q   <= '0;
    end else begin
      count_q <= count_q + CNT_W'(1);
      if (cmp_we_i) cmp_q <= cmp_wdata_i;
    end
  end

  // a zero count never counts as a match
  assign match_o = (cmp_q == count_q) && (count_q != '0);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
    assign tset_o[i] = match_o && (tsel_i == SEL_W'(i));
  end

  assign count_o = count_q;
  assign cmp_o   = cmp_q;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pend_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t post_i,
  input  line_vec_t clr_i,
  input  logic      clr_all_i,
  input  line_vec_t tset_i,
  output line_vec_t pend_d_o,
  output line_vec_t pend_q_o
);
  line_vec_t pend_q;
  line_vec_t pend_d;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
    // priority: clear-all, then per-line clear, then set sources
    always_comb begin
      if (clr_all_i)                   pend_d[i] = 1'b0;
      else if (clr_i[i])               pend_d[i] = 1'b0;
      else if (post_i[i] || tset_i[i]) pend_d[i] = 1'b1;
      else                             pend_d[i] = pend_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end
  end

  assign pend_d_o = pend_d;
  assign pend_q_o = pend_q;
endmodule

// File: rtl/irq_take.sv
module irq_take
  import irq_pend_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      gie_i,
  input  logic      exl_i,
  input  logic      erl_i,
  input  line_vec_t mask_i,
  input  line_vec_t pend_next_i,
  output logic      irq_o
);
  logic gate_open;
  logic unmasked_hit;
  logic irq_q;

  assign gate_open    = gie_i && !exl_i && !erl_i;
  assign unmasked_hit = |(mask_i & pend_next_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= gate_open && unmasked_hit;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pend_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       post_i,
  input  logic [7:0]       clr_i,
  input  logic             clr_all_i,
  input  logic             gie_i,
  input  logic             exl_i,
  input  logic             erl_i,
  input  logic [7:0]       mask_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic [2:0]       tsel_i,
  output logic [CNT_W-1:0] count_o,
  output logic [7:0]       pend_o,
  output logic             any_pend_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cmp_val;
  logic             tmr_match;
  line_vec_t        tmr_set;
  line_vec_t        pend_next;
  line_vec_t        pend_cur;

  irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmp_we_i    (cmp_we_i),
    .cmp_wdata_i (cmp_wdata_i),
    .tsel_i      (tsel_i),
    .count_o     (count_o),
    .cmp_o       (cmp_val),
    .match_o     (tmr_match),
    .tset_o      (tmr_set)
  );

  irq_pend_reg u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .post_i    (post_i),
    .clr_i     (clr_i),
    .clr_all_i (clr_all_i),
    .tset_i    (tmr_set),
    .pend_d_o  (pend_next),
    .pend_q_o  (pend_cur)
  );

  irq_take u_take (
    .clk         (clk),
    .rst_n       (rst_n),
    .gie_i       (gie_i),
    .exl_i       (exl_i),
    .erl_i       (erl_i),
    .mask_i      (mask_i),
    .pend_next_i (pend_next),
    .irq_o       (irq_o)
  );

  assign pend_o     = pend_cur;
  assign any_pend_o = (|pend_cur) || tmr_match;
endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       post_i,
  input logic [7:0]       clr_i,
  input logic             clr_all_i,
  input logic             gie_i,
  input logic             exl_i,
  input logic             erl_i,
  input logic [7:0]       mask_i,
  input logic [2:0]       tsel_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cmp_val,
  input logic [7:0]       pend_o,
  input logic             any_pend_o,
  input logic             irq_o
);
  AST_POST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all_i |=> ((pend_o & $past(post_i & ~clr_i)) == $past(post_i & ~clr_i))); // R2

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != 8'h00) |=> ((pend_o & $past(clr_i)) == 8'h00)); // R3

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> (pend_o == 8'h00)); // R4

  AST_STATUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_i || exl_i || erl_i) |=> !irq_o); // R5

  AST_MASK_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((pend_o & $past(mask_i)) != 8'h00)); // R6

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (count_o == CNT_W'($past(count_o) + CNT_W'(1)))); // R7

  AST_TIMER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_val == count_o) && (count_o != '0) && !clr_all_i && !clr_i[tsel_i])
      |=> pend_o[$past(tsel_i)]); // R8

  AST_ANY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o != 8'h00) |-> any_pend_o); // R10
endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .post_i     (post_i),
  .clr_i      (clr_i),
  .clr_all_i  (clr_all_i),
  .gie_i      (gie_i),
  .exl_i      (exl_i),
  .erl_i      (erl_i),
  .mask_i     (mask_i),
  .tsel_i     (tsel_i),
  .count_o    (count_o),
  .cmp_val    (cmp_val),
  .pend_o     (pend_o),
  .any_pend_o (any_pend_o),
  .irq_o      (irq_o)
);

// File: tb/test_irq_pend_ctrl.sv
`timescale 1ns/1ps
module test_irq_pend_ctrl;
  localparam int unsigned CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    post_i = '0, clr_i = '0, mask_i = '0;
  logic          clr_all_i = 1'b0, gie_i = 1'b0, exl_i = 1'b0, erl_i = 1'b0;
  logic          cmp_we_i = 1'b0;
  logic [CW-1:0] cmp_wdata_i = '0;
  logic [2:0]    tsel_i = '0;
  logic [CW-1:0] count_o;
  logic [7:0]    pend_o;
  logic          any_pend_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_pend_ctrl #(.CNT_W(CW)) i_irq_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .post_i(post_i), .clr_i(clr_i),
    .clr_all_i(clr_all_i), .gie_i(gie_i), .exl_i(exl_i), .erl_i(erl_i),
    .mask_i(mask_i), .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i),
    .tsel_i(tsel_i), .count_o(count_o), .pend_o(pend_o),
    .any_pend_o(any_pend_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    step();
    chk("R1", "pend at reset", 32'(pend_o), 32'h0);
    chk("R1", "irq at reset", 32'(irq_o), 32'h0);
    chk("R1", "count at reset", 32'(count_o), 32'h0);
    rst_n = 1'b1;
    // compare is 0 and count is 0 right after reset: no match
    chk("R1", "no match on zero compare", 32'(any_pend_o), 32'h0);
    step();
    chk("R7", "count steps", 32'(count_o), 32'h1);
  endtask

  task automatic t_post_clear();
    post_i = 8'h05; step(); post_i = '0;
    chk("R2", "post lines 0,2", 32'(pend_o), 32'h05);
    post_i = 8'h80; step(); post_i = '0;
    chk("R2", "post line 7 keeps others", 32'(pend_o), 32'h85);
    clr_i = 8'h04; step(); clr_i = '0;
    chk("R3", "clear line 2", 32'(pend_o), 32'h81);
    post_i = 8'h12; clr_i = 8'h10; step(); post_i = '0; clr_i = '0;
    chk("R3", "clear beats post on line 4", 32'(pend_o), 32'h83);
    chk("R10", "any pending", 32'(any_pend_o), 32'h1);
    post_i = 8'h40; clr_all_i = 1'b1; step(); post_i = '0; clr_all_i = 1'b0;
    chk("R4", "clear all beats post", 32'(pend_o), 32'h00);
    chk("R10", "any pending low", 32'(any_pend_o), 32'h0);
  endtask

  task automatic t_gate();
    mask_i = 8'h04; gie_i = 1'b1;
    post_i = 8'h04; step(); post_i = '0;
    chk("R5", "irq with gate open", 32'(irq_o), 32'h1);
    exl_i = 1'b1; step();
    chk("R5", "exception level blocks", 32'(irq_o), 32'h0);
    exl_i = 1'b0; erl_i = 1'b1; step();
    chk("R5", "error level blocks", 32'(irq_o), 32'h0);
    erl_i = 1'b0; gie_i = 1'b0; step();
    chk("R5", "disable blocks", 32'(irq_o), 32'h0);
    gie_i = 1'b1; step();
    chk("R5", "reopened", 32'(irq_o), 32'h1);
    mask_i = 8'hFB; step();
    chk("R6", "masked line alone no irq", 32'(irq_o), 32'h0);
    chk("R6", "pending kept", 32'(pend_o), 32'h04);
    clr_all_i = 1'b1; step(); clr_all_i = 1'b0;
    gie_i = 1'b0; mask_i = '0;
  endtask

  task automatic arm_timer(input logic [2:0] sel, output logic [CW-1:0] tgt);
    tgt = count_o + CW'(4);
    if (tgt == '0) tgt = CW'(5);
    tsel_i = sel; cmp_wdata_i = tgt; cmp_we_i = 1'b1;
    step(); cmp_we_i = 1'b0;
    for (int k = 0; k < 300 && count_o != tgt; k++) step();
  endtask

  task automatic t_timer();
    logic [CW-1:0] tgt;
    arm_timer(3'd5, tgt);
    chk("R7", "count reached target", 32'(count_o), 32'(tgt));
    chk("R10", "any pending on match", 32'(any_pend_o), 32'h1);
    chk("R8", "not yet set", 32'(pend_o), 32'h0);
    step();
    chk("R8", "timer sets line 5", 32'(pend_o), 32'h20);
    clr_all_i = 1'b1; step(); clr_all_i = 1'b0;
    arm_timer(3'd1, tgt);
    clr_all_i = 1'b1; step(); clr_all_i = 1'b0;
    chk("R4", "clear all beats timer", 32'(pend_o), 32'h0);
  endtask

  task automatic t_zero();
    cmp_wdata_i = '0; cmp_we_i = 1'b1; step(); cmp_we_i = 1'b0;
    for (int k = 0; k < 300 && count_o != '0; k++) step();
    chk("R7", "count wrapped", 32'(count_o), 32'h0);
    chk("R9", "no match at zero", 32'(any_pend_o), 32'h0);
    step();
    chk("R9", "no set at zero", 32'(pend_o), 32'h0);
  endtask

  initial begin
    t_reset();
    t_post_clear();
    t_gate();
    t_timer();
    t_zero();
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 20000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule